// File: doc/BRIEF.md
# Bufferless Deflection Router Node

This block is one node of a packet-switched on-chip network that has no packet storage. It has three bidirectional network links plus a local port that can inject one packet into the network and eject one packet from it. On every cycle each packet that arrives on a network link leaves the node on the next cycle, either on a network output or through the eject port. No packet is held back. A packet carries a destination node number, a 4-bit priority and a data word.

The node first works out which output each packet wants. Packets addressed to this node want the eject port. Any other packet wants the lowest-numbered link whose reachable destination range contains its destination, or link 0 if no range matches. Contending packets are then served one at a time, highest priority first. A packet that finds its wanted output already taken is sent out on a free link and its priority goes up by one. That priority stops at 15, so a packet that has been deflected many times wins its port over everything of lower priority. A local packet may be injected only when a network output is still free after all arriving packets are placed.

Top module: `dr_router`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, every network output valid bit and the eject valid bit are 0.
- R2: Every packet that is valid on a network input in a cycle appears exactly once in the next cycle, on one network output or on the eject port. No packet is lost, duplicated or held.
- R3: The wanted output of an arriving packet is the eject port when its destination equals the local node number, which defaults to 5. Otherwise it is the lowest link whose range contains the destination. The default ranges are link 0 for 0..4, link 1 for 6..10 and link 2 for 11..15. A destination that no range contains wants link 0.
- R4: A packet that gets its wanted output leaves with its destination, priority and data unchanged.
- R5: Packets are served in order of descending priority. Among equal priorities the lower input index is served first. The first packet served always gets its wanted output.
- R6: A packet whose wanted output is already taken leaves on the lowest-numbered free network link, and its priority is increased by one.
- R7: The priority increase saturates. A deflected packet with priority 15 leaves with priority 15.
- R8: A packet with priority 15 wins its wanted output against any packet of lower priority.
- R9: At most one packet is ejected per cycle. Any other packet addressed to this node is deflected onto a network link as in R6.
- R10: The inject ready output is 1 exactly when a network link is still free after all arriving packets are placed. An accepted injected packet is placed after them, on the link chosen by the range table alone (it is never ejected) if that link is free, and otherwise on the lowest free link, with its priority unchanged. An injected packet offered while ready is 0 appears on no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS | Arriving packet present, one bit per link |
| in_dest | input | N_PORTS x ID_W | Destination node of each arriving packet |
| in_prio | input | N_PORTS x PRIO_W | Priority of each arriving packet |
| in_data | input | N_PORTS x DATA_W | Data word of each arriving packet |
| inj_valid | input | 1 | Local packet offered for injection |
| inj_dest | input | ID_W | Destination of the offered local packet |
| inj_prio | input | PRIO_W | Priority of the offered local packet |
| inj_data | input | DATA_W | Data of the offered local packet |
| inj_ready | output | 1 | Injection accepted this cycle if offered |
| out_valid | output | N_PORTS | Departing packet present, one bit per link |
| out_dest | output | N_PORTS x ID_W | Destination of each departing packet |
| out_prio | output | N_PORTS x PRIO_W | Priority of each departing packet |
| out_data | output | N_PORTS x DATA_W | Data of each departing packet |
| ej_valid | output | 1 | Packet delivered to the local node |
| ej_prio | output | PRIO_W | Priority of the delivered packet |
| ej_data | output | DATA_W | Data of the delivered packet |

## Verification
The node keeps no state from one cycle to the next apart from its output registers. A wrong rank, a wrong wanted output or a corrupted free-slot vector therefore shows up in the very next cycle, as a missing or duplicated packet, a packet on the wrong link or a priority off by one. The bench exploits this by comparing every output slot, one cycle after each stimulus, against a model that walks the priorities from 15 down. Conflicts, saturation, double ejection and injection at full and partial load are each driven on purpose.

// File: rtl/dr_pkg.sv
package dr_pkg;
  parameter int unsigned ID_W   = 4;
  parameter int unsigned PRIO_W = 4;
  parameter int unsigned DATA_W = 16;

  localparam logic [PRIO_W-1:0] PRIO_TOP = '1;

  typedef struct packed {
    logic [ID_W-1:0]   dest;
    logic [PRIO_W-1:0] prio;
    logic [DATA_W-1:0] data;
  } flit_t;

  // saturating priority raise applied to a deflected packet
  function automatic logic [PRIO_W-1:0] prio_raise(input logic [PRIO_W-1:0] p);
    logic [PRIO_W-1:0] r;
    if (p == PRIO_TOP) r = p;
    else               r = p + 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dr_route.sv
module dr_route
  import dr_pkg::*;
#(
  parameter int unsigned                     N_PORTS     = 3,
  parameter int unsigned                     SEL_W       = 2,
  parameter bit                              ALLOW_EJECT = 1'b1,
  parameter logic [ID_W-1:0]                 LOCAL_ID    = ID_W'(5),
  parameter logic [N_PORTS-1:0][ID_W-1:0]    RANGE_LO    = '0,
  parameter logic [N_PORTS-1:0][ID_W-1:0]    RANGE_HI    = '1
) (
  input  logic [ID_W-1:0]  dest,
  output logic [SEL_W-1:0] want
);
  localparam logic [SEL_W-1:0] SEL_EJECT = SEL_W'(N_PORTS);

  logic [N_PORTS-1:0] hit;

  // modular distance test keeps a single comparison per range
  genvar g;
  generate
    for (g = 0; g < N_PORTS; g++) begin : g_hit
      assign hit[g] = ID_W'(dest - RANGE_LO[g]) <= ID_W'(RANGE_HI[g] - RANGE_LO[g]);
    end
  endgenerate

  always_comb begin
    want = '0;
    for (int p = N_PORTS - 1; p >= 0; p--) begin
      if (hit[p]) want = SEL_W'(p);
    end
    if (ALLOW_EJECT && (dest == LOCAL_ID)) want = SEL_EJECT;
  end
endmodule

// File: rtl/dr_rank.sv
module dr_rank
  import dr_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter int unsigned RANK_W  = 2
) (
  input  logic [N_PORTS-1:0]             valid,
  input  logic [N_PORTS-1:0][PRIO_W-1:0] prio,
  output logic [N_PORTS-1:0][RANK_W-1:0] rank
);
  // rank = number of valid packets served ahead of this one
  always_comb begin
    rank = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      for (int j = 0; j < N_PORTS; j++) begin
        if ((j != i) && valid[j] &&
            ((prio[j] > prio[i]) || ((prio[j] == prio[i]) && (j < i)))) begin
          rank[i] = rank[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dr_alloc.sv
module dr_alloc
  import dr_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned RANK_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_sn,
  input  logic [N_PORTS-1:0]              req_valid,
  input  logic [N_PORTS-1:0][SEL_W-1:0]   req_want,
  input  logic [N_PORTS-1:0][RANK_W-1:0]  req_rank,
  input  logic [N_PORTS-1:0][PRIO_W-1:0]  req_prio,
  input  logic                            inj_valid,
  input  logic [SEL_W-1:0]                inj_want,
  output logic [N_PORTS-1:0][SEL_W-1:0]   grant,
  output logic [N_PORTS-1:0]              deflect,
  output logic                            inj_ready,
  output logic [SEL_W-1:0]                inj_grant
);
  // bit N_PORTS of the free vector stands for the eject slot
  logic [N_PORTS:0] free_v;
  logic             placed;

  always_comb begin
    free_v    = '1;
    grant     = '0;
    deflect   = '0;
    inj_grant = '0;
    placed    = 1'b0;
    for (int k = 0; k < N_PORTS; k++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (req_valid[i] && (req_rank[i] == RANK_W'(k))) begin
          if (free_v[req_want[i]]) begin
            grant[i]              = req_want[i];
            free_v[req_want[i]]   = 1'b0;
          end else begin
            deflect[i] = 1'b1;
            placed     = 1'b0;
            for (int p = 0; p < N_PORTS; p++) begin
              if (!placed && free_v[p]) begin
                grant[i]  = SEL_W'(p);
                free_v[p] = 1'b0;
                placed    = 1'b1;
              end
            end
          end
        end
      end
    end
    inj_ready = |free_v[N_PORTS-1:0];
    if (free_v[inj_want]) begin
      inj_grant = inj_want;
    end else begin
      placed = 1'b0;
      for (int p = 0; p < N_PORTS; p++) begin
        if (!placed && free_v[p]) begin
          inj_grant = SEL_W'(p);
          placed    = 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_PORTS; g++) begin : g_chk
      // R5: the packet served first is never deflected
      assert_first_served_R5: assert property (@(posedge clk) disable iff (!rst_sn)
        (req_valid[g] && (req_rank[g] == '0)) |-> !deflect[g]);
      // R8: a saturated packet served first keeps its wanted output
      assert_top_keeps_port_R8: assert property (@(posedge clk) disable iff (!rst_sn)
        (req_valid[g] && (req_prio[g] == PRIO_TOP) && (req_rank[g] == '0)) |-> (grant[g] == req_want[g]));
    end
  endgenerate
endmodule

// File: rtl/dr_router.sv
module dr_router
  import dr_pkg::*;
#(
  parameter int unsigned                  N_PORTS  = 3,
  parameter logic [ID_W-1:0]              LOCAL_ID = ID_W'(5),
  parameter logic [N_PORTS-1:0][ID_W-1:0] RANGE_LO = {ID_W'(11), ID_W'(6), ID_W'(0)},
  parameter logic [N_PORTS-1:0][ID_W-1:0] RANGE_HI = {ID_W'(15), ID_W'(10), ID_W'(4)}
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_PORTS-1:0]               in_valid,
  input  logic [N_PORTS-1:0][ID_W-1:0]     in_dest,
  input  logic [N_PORTS-1:0][PRIO_W-1:0]   in_prio,
  input  logic [N_PORTS-1:0][DATA_W-1:0]   in_data,
  input  logic                             inj_valid,
  input  logic [ID_W-1:0]                  inj_dest,
  input  logic [PRIO_W-1:0]                inj_prio,
  input  logic [DATA_W-1:0]                inj_data,
  output logic                             inj_ready,
  output logic [N_PORTS-1:0]               out_valid,
  output logic [N_PORTS-1:0][ID_W-1:0]     out_dest,
  output logic [N_PORTS-1:0][PRIO_W-1:0]   out_prio,
  output logic [N_PORTS-1:0][DATA_W-1:0]   out_data,
  output logic                             ej_valid,
  output logic [PRIO_W-1:0]                ej_prio,
  output logic [DATA_W-1:0]                ej_data
);
  localparam int unsigned      SEL_W     = $clog2(N_PORTS + 1);
  localparam int unsigned      RANK_W    = $clog2(N_PORTS + 1);
  localparam logic [SEL_W-1:0] SEL_EJECT = SEL_W'(N_PORTS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // per-input flits and wanted outputs
  flit_t [N_PORTS-1:0]             in_flit;
  logic  [N_PORTS-1:0][SEL_W-1:0]  want;
  logic  [SEL_W-1:0]               inj_want;
  flit_t                           inj_flit;

  genvar g;
  generate
    for (g = 0; g < N_PORTS; g++) begin : g_in
      assign in_flit[g] = '{dest: in_dest[g], prio: in_prio[g], data: in_data[g]};
      dr_route #(
        .N_PORTS(N_PORTS), .SEL_W(SEL_W), .ALLOW_EJECT(1'b1),
        .LOCAL_ID(LOCAL_ID), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
      ) i_route (
        .dest(in_dest[g]),
        .want(want[g])
      );
    end
  endgenerate

  assign inj_flit = '{dest: inj_dest, prio: inj_prio, data: inj_data};

  dr_route #(
    .N_PORTS(N_PORTS), .SEL_W(SEL_W), .ALLOW_EJECT(1'b0),
    .LOCAL_ID(LOCAL_ID), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) i_route_inj (
    .dest(inj_dest),
    .want(inj_want)
  );

  logic [N_PORTS-1:0][RANK_W-1:0] rank;

  dr_rank #(.N_PORTS(N_PORTS), .RANK_W(RANK_W)) i_rank (
    .valid(in_valid),
    .prio (in_prio),
    .rank (rank)
  );

  logic [N_PORTS-1:0][SEL_W-1:0] grant;
  logic [N_PORTS-1:0]            deflect;
  logic [SEL_W-1:0]              inj_grant;

  dr_alloc #(.N_PORTS(N_PORTS), .SEL_W(SEL_W), .RANK_W(RANK_W)) i_alloc (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .req_valid(in_valid),
    .req_want (want),
    .req_rank (rank),
    .req_prio (in_prio),
    .inj_valid(inj_valid),
    .inj_want (inj_want),
    .grant    (grant),
    .deflect  (deflect),
    .inj_ready(inj_ready),
    .inj_grant(inj_grant)
  );

  // next-state: steer every flit into its granted slot
  logic [N_PORTS-1:0] out_valid_d;
  flit_t [N_PORTS-1:0] out_flit_d;
  logic               ej_valid_d;
  flit_t              ej_flit_d;
  flit_t              cur;

  always_comb begin
    out_valid_d = '0;
    out_flit_d  = '0;
    ej_valid_d  = 1'b0;
    ej_flit_d   = '0;
    cur         = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (in_valid[i]) begin
        cur = in_flit[i];
        if (deflect[i]) cur.prio = prio_raise(in_flit[i].prio);
        if (grant[i] == SEL_EJECT) begin
          ej_valid_d = 1'b1;
          ej_flit_d  = cur;
        end else begin
          out_valid_d[grant[i]] = 1'b1;
          out_flit_d[grant[i]]  = cur;
        end
      end
    end
    if (inj_valid && inj_ready) begin
      out_valid_d[inj_grant] = 1'b1;
      out_flit_d[inj_grant]  = inj_flit;
    end
  end

  // registers: valid bits every cycle, payload only where a flit lands
  logic [N_PORTS-1:0]  out_valid_q;
  flit_t [N_PORTS-1:0] out_flit_q;
  logic                ej_valid_q;
  flit_t               ej_flit_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid_q <= '0;
      ej_valid_q  <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      ej_valid_q  <= ej_valid_d;
    end
  end

  generate
    for (g = 0; g < N_PORTS; g++) begin : g_out
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn)             out_flit_q[g] <= '0;
        else if (out_valid_d[g]) out_flit_q[g] <= out_flit_d[g];
      end
      assign out_dest[g] = out_flit_q[g].dest;
      assign out_prio[g] = out_flit_q[g].prio;
      assign out_data[g] = out_flit_q[g].data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         ej_flit_q <= '0;
    else if (ej_valid_d) ej_flit_q <= ej_flit_d;
  end

  assign out_valid = out_valid_q;
  assign ej_valid  = ej_valid_q;
  assign ej_prio   = ej_flit_q.prio;
  assign ej_data   = ej_flit_q.data;

  // checks at the block's edge
  logic [N_PORTS-1:0] local_hit;
  generate
    for (g = 0; g < N_PORTS; g++) begin : g_loc
      assign local_hit[g] = in_valid[g] && (in_dest[g] == LOCAL_ID);
    end
  endgenerate

  // R1: nothing leaves while the internal reset is held
  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_sn |-> (out_valid == '0) && !ej_valid);

  // R2: departing count equals arriving plus accepted injection
  assert_conserve_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (int'($countones(out_valid)) + int'(ej_valid)) ==
             $past(int'($countones(in_valid)) + int'(inj_valid && inj_ready)));

  // R9: no ejection without a locally addressed arrival
  assert_eject_local_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(|local_hit) |=> !ej_valid);

  // R10: full link load with nothing to eject blocks injection
  assert_inject_gate_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    ((&in_valid) && !(|local_hit)) |-> !inj_ready);
endmodule

// File: tb/test_dr_router.sv
module test_dr_router;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NP-1:0]       in_valid;
  logic [NP-1:0][3:0]  in_dest;
  logic [NP-1:0][3:0]  in_prio;
  logic [NP-1:0][15:0] in_data;
  logic        inj_valid;
  logic [3:0]  inj_dest;
  logic [3:0]  inj_prio;
  logic [15:0] inj_data;
  logic        inj_ready;
  logic [NP-1:0]       out_valid;
  logic [NP-1:0][3:0]  out_dest;
  logic [NP-1:0][3:0]  out_prio;
  logic [NP-1:0][15:0] out_data;
  logic        ej_valid;
  logic [3:0]  ej_prio;
  logic [15:0] ej_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_router i_dr_router (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_dest(in_dest), .in_prio(in_prio), .in_data(in_data),
    .inj_valid(inj_valid), .inj_dest(inj_dest), .inj_prio(inj_prio), .inj_data(inj_data),
    .inj_ready(inj_ready),
    .out_valid(out_valid), .out_dest(out_dest), .out_prio(out_prio), .out_data(out_data),
    .ej_valid(ej_valid), .ej_prio(ej_prio), .ej_data(ej_data)
  );

  typedef struct {
    logic [NP-1:0]       ov;
    logic [NP-1:0][3:0]  od;
    logic [NP-1:0][3:0]  op;
    logic [NP-1:0][15:0] odat;
    logic                ev;
    logic [3:0]          ep;
    logic [15:0]         edat;
    string               tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   seq      = 0;
  bit   done     = 0;

  // wanted output per R3 with the default table; 3 = eject
  function automatic int want_of(input logic [3:0] d, input bit may_eject);
    if (may_eject && d == 4'd5) return 3;
    if (d <= 4'd4)              return 0;
    if (d >= 4'd6 && d <= 4'd10) return 1;
    if (d >= 4'd11)             return 2;
    return 0;
  endfunction

  function automatic int lowest_free(input logic [3:0] fr);
    for (int p = 0; p < NP; p++) if (fr[p]) return p;
    return -1;
  endfunction

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic drive(input logic [2:0] v, input logic [2:0][3:0] d, input logic [2:0][3:0] p,
                       input logic iv, input logic [3:0] idst, input logic [3:0] ipr,
                       input string tag);
    exp_t e;
    logic [3:0] fr;
    bit   rdy;
    int   w, g;
    logic [3:0] np;
    @(negedge clk);
    seq++;
    in_valid = v;
    in_dest  = d;
    in_prio  = p;
    for (int i = 0; i < NP; i++) in_data[i] = 16'(seq * 8 + i);
    inj_valid = iv;
    inj_dest  = idst;
    inj_prio  = ipr;
    inj_data  = 16'(seq * 8 + 7);
    e.ov = '0; e.od = '0; e.op = '0; e.odat = '0; e.ev = 1'b0; e.ep = '0; e.edat = '0;
    e.tag = tag;
    fr = 4'b1111;
    for (int pr = 15; pr >= 0; pr--) begin
      for (int i = 0; i < NP; i++) begin
        if (v[i] && int'(p[i]) == pr) begin
          w = want_of(d[i], 1'b1);
          np = p[i];
          if (fr[w]) g = w;
          else begin
            g = lowest_free(fr);
            np = (p[i] == 4'd15) ? 4'd15 : p[i] + 4'd1;
          end
          fr[g] = 1'b0;
          if (g == 3) begin e.ev = 1'b1; e.ep = np; e.edat = in_data[i]; end
          else begin e.ov[g] = 1'b1; e.od[g] = d[i]; e.op[g] = np; e.odat[g] = in_data[i]; end
        end
      end
    end
    rdy = |fr[2:0];
    if (iv && rdy) begin
      w = want_of(idst, 1'b0);
      g = fr[w] ? w : lowest_free(fr);
      e.ov[g] = 1'b1; e.od[g] = idst; e.op[g] = ipr; e.odat[g] = inj_data;
    end
    exp_q.push_back(e);
    #1;
    n_checks++;
    if (inj_ready !== rdy) begin
      n_fails++;
      $display("FAIL R10 inj_ready [%s]: actual %b expected %b", tag, inj_ready, rdy);
    end
  endtask

  // monitor: compare outputs one cycle after the stimulus was applied
  initial begin
    exp_t e;
    bit   bad;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        bad = (out_valid !== e.ov) || (ej_valid !== e.ev);
        for (int p = 0; p < NP; p++)
          if (e.ov[p] && (out_dest[p] !== e.od[p] || out_prio[p] !== e.op[p] || out_data[p] !== e.odat[p]))
            bad = 1;
        if (e.ev && (ej_prio !== e.ep || ej_data !== e.edat)) bad = 1;
        n_checks++;
        if (bad) begin
          n_fails++;
          $display("FAIL %s: actual v=%b d=%h p=%h dat=%h ej=%b/%h/%h expected v=%b d=%h p=%h dat=%h ej=%b/%h/%h",
                   e.tag, out_valid, out_dest, out_prio, out_data, ej_valid, ej_prio, ej_data,
                   e.ov, e.od, e.op, e.odat, e.ev, e.ep, e.edat);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual run still going, expected completion");
      finish_test();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_dest = '0; in_prio = '0; in_data = '0;
    inj_valid = 1'b0; inj_dest = '0; inj_prio = '0; inj_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    n_checks++;
    if (out_valid !== '0 || ej_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: actual v=%b ej=%b expected 000/0", out_valid, ej_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== '0 || ej_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 release: actual v=%b ej=%b expected 000/0", out_valid, ej_valid);
    end

    drive(3'b111, {4'd12, 4'd7, 4'd2}, {4'd0, 4'd0, 4'd0}, 0, 0, 0, "R3 R4 each link wanted once");
    drive(3'b001, {4'd0, 4'd0, 4'd5}, {4'd0, 4'd0, 4'd4}, 0, 0, 0, "R3 local eject");
    drive(3'b111, {4'd7, 4'd7, 4'd7}, {4'd7, 4'd7, 4'd3}, 0, 0, 0, "R5 R6 three-way conflict");
    drive(3'b011, {4'd0, 4'd9, 4'd9}, {4'd0, 4'd15, 4'd15}, 0, 0, 0, "R7 saturated deflect");
    drive(3'b101, {4'd8, 4'd0, 4'd8}, {4'd15, 4'd0, 4'd14}, 0, 0, 0, "R8 top priority wins");
    drive(3'b110, {4'd5, 4'd5, 4'd0}, {4'd2, 4'd9, 4'd0}, 0, 0, 0, "R9 double eject");
    drive(3'b001, {4'd0, 4'd0, 4'd2}, {4'd0, 4'd0, 4'd1}, 1, 4'd2, 4'd6, "R10 inject deflected");
    drive(3'b111, {4'd12, 4'd7, 4'd2}, {4'd1, 4'd1, 4'd1}, 1, 4'd13, 4'd2, "R10 inject refused");
    drive(3'b111, {4'd12, 4'd7, 4'd5}, {4'd1, 4'd1, 4'd1}, 1, 4'd5, 4'd3, "R10 R3 inject never ejects");
    drive(3'b000, {4'd0, 4'd0, 4'd0}, {4'd0, 4'd0, 4'd0}, 1, 4'd13, 4'd9, "R10 inject alone");
    drive(3'b000, {4'd0, 4'd0, 4'd0}, {4'd0, 4'd0, 4'd0}, 0, 0, 0, "R2 idle");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] rv;
      logic [2:0][3:0] rd, rp;
      rv = 3'($urandom_range(0, 7));
      for (int i = 0; i < NP; i++) begin
        rd[i] = 4'($urandom_range(0, 15));
        rp[i] = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
      end
      drive(rv, rd, rp, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
            4'($urandom_range(0, 15)), "R2 R5 R6 random traffic");
    end
    drive(3'b000, {4'd0, 4'd0, 4'd0}, {4'd0, 4'd0, 4'd0}, 0, 0, 0, "R2 drain");
    repeat (3) @(negedge clk);
    done = 1;
    finish_test();
  end
endmodule